// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital controller of a serially interfaced successive-approximation converter. It is clocked by the host's serial clock and framed by an active-low select, `cs_n`. While `cs_n` is low, the host sends a start bit and then a channel address on `di`. The sequencer then latches the channel and runs one comparison step per clock. In each step it presents a trial code to an external DAC and reads back one comparator decision on `comp_hi`. The DAC, the comparator, the multiplexer and the reference are outside the block and are seen only through ports.

Each decision leaves the block on `do_o` half a clock after it is made, MSB first. A zero slot comes before the first decision. With `LSB_REPLAY` set, the finished word is sent a second time, LSB first. `do_oe` stays low whenever `di` is being listened to, so the two pins can share one wire. `busy` marks the conversion window. Raising `cs_n` at any time clears everything.

The controller states are:
- `ST_IDLE`: waiting for the start bit.
- `ST_ADDR`: shifting in the address bits.
- `ST_CONV`: running the comparison steps.
- `ST_TAIL`: showing the LSB slot.
- `ST_REPLAY`: sending the LSB-first copy.
- `ST_DONE`: output parked, waiting for `cs_n` to rise.

The transitions are:
- `ST_IDLE` to `ST_ADDR`: a one is sampled on `di`.
- `ST_ADDR` to `ST_CONV`: the last address bit is sampled.
- `ST_CONV` to `ST_TAIL`: the last comparison step is done.
- `ST_TAIL` to `ST_REPLAY` when replay is enabled, otherwise to `ST_DONE`.
- `ST_REPLAY` to `ST_DONE`: the last replay bit has been sent.
- Any state to `ST_IDLE`, asynchronously, while `cs_n` is high.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is high, all state is cleared at once, even in mid-conversion. `busy`, `do_oe`, `mux_addr` and `trial_code` all read 0.
- R2: After `cs_n` falls, the block stays idle while `di` samples 0 on rising edges. The first 1 sampled is the start bit.
- R3: The 3 bits after the start bit are the channel address, sampled on rising edges. The first of them lands in `mux_addr[2]`. `mux_addr` is updated on the rising edge that samples the last of them, and it holds through the conversion.
- R4: `busy` rises on the falling edge after the last address bit is sampled. It falls 8 clock periods later, on the falling edge after the 8th decision.
- R5: On that same first falling edge, `do_oe` rises and `do_o` drives a 0 for one clock period (the leading slot).
- R6: Step k (k = 0 for the MSB) presents `trial_code` = (bits already decided) OR (1 at bit 7-k); the first trial is 8'h80. The bit is kept when `comp_hi` is 1 at the rising edge, and cleared otherwise. A kept bit is never lost.
- R7: Each decision appears on `do_o` at the falling edge after the rising edge that made it, MSB first. The 8 slots after the leading zero carry result bits 7 down to 0.
- R8: With `LSB_REPLAY`=1, 8 more slots follow the LSB slot and carry result bits 0 up to 7. With `LSB_REPLAY`=0, nothing follows.
- R9: After the last slot, `do_oe` goes low and stays low until `cs_n` goes high. Further start bits are ignored until then.
- R10: `di` has no effect from the latching of the address until `cs_n` rises.
- R11: `do_oe` is low on every rising edge at which `di` is sampled (idle and address phases).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select; high clears all state asynchronously |
| di | input | 1 | Serial start bit and address, sampled on rising edges |
| comp_hi | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| trial_code | output | 8 | Trial code for the external DAC |
| mux_addr | output | 3 | Latched channel address for the external multiplexer |
| busy | output | 1 | Conversion in progress |
| do_o | output | 1 | Serial result data, updated on falling edges |
| do_oe | output | 1 | Output enable for the serial data driver |

## Verification
The assertions guard the following on every rising edge:
- the quiet output during the idle and address phases;
- the leading zero slot;
- the match between `busy` and the comparison state;
- the parked output after the last slot;
- the held channel;
- the rule that a kept SAR bit is never lost.

Only the bench scenarios can show the rest. A scoreboard replays the expected serial stream for each analog value through an independent comparator model, in both the replay and the MSB-only variants. The scenarios also count the busy window, toggle `di` during conversion, abort a conversion mid-way, and attempt a restart without a select cycle.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CONV,
        ST_TAIL,
        ST_REPLAY,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/sar_addr_shift.sv
module sar_addr_shift #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          latch_en,
    input  logic          di,
    output logic [AW-1:0] addr_o
);
    logic [AW-2:0] sh;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            sh     <= '0;
            addr_o <= '0;
        end else begin
            if (shift_en) sh <= {sh[AW-3:0], di};
            if (latch_en) addr_o <= {sh, di};
        end
    end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             active,
    input  logic [CNT_W-1:0] step_idx,
    input  logic             comp_hi,
    output logic [W-1:0]     trial,
    output logic [W-1:0]     sar
);
    localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        trial = active ? (sar | (MSB_ONE >> step_idx)) : '0;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            sar <= '0;
        end else if (active && comp_hi) begin
            sar <= trial;
        end
    end

    AST_SAR_MONO: assert property (@(posedge clk) disable iff (clr)
        active |=> ((sar & $past(sar)) == $past(sar))); // R6
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
    import sar_seq_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  seq_state_t       state,
    input  logic [CNT_W-1:0] cnt,
    input  logic [W-1:0]     sar,
    output logic             do_o,
    output logic             do_oe,
    output logic             busy
);
    logic             do_nx;
    logic             oe_nx;
    logic             busy_nx;
    logic [CNT_W-1:0] pos;

    always_comb begin
        pos     = CNT_W'(W - 1) - (cnt - CNT_W'(1));
        do_nx   = 1'b0;
        oe_nx   = 1'b0;
        busy_nx = 1'b0;
        unique case (state)
            ST_IDLE, ST_ADDR, ST_DONE: begin
                do_nx = 1'b0;
            end
            ST_CONV: begin
                oe_nx   = 1'b1;
                busy_nx = 1'b1;
                do_nx   = (cnt == '0) ? 1'b0 : sar[pos];
            end
            ST_TAIL: begin
                oe_nx = 1'b1;
                do_nx = sar[0];
            end
            ST_REPLAY: begin
                oe_nx = 1'b1;
                do_nx = sar[cnt];
            end
            default: begin
                do_nx = 1'b0;
            end
        endcase
    end

    always_ff @(negedge clk or posedge clr) begin
        if (clr) begin
            do_o  <= 1'b0;
            do_oe <= 1'b0;
            busy  <= 1'b0;
        end else begin
            do_o  <= do_nx;
            do_oe <= oe_nx;
            busy  <= busy_nx;
        end
    end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
    import sar_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 3,
    parameter bit LSB_REPLAY = 1'b1
) (
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              di,
    input  logic              comp_hi,
    output logic [DATA_W-1:0] trial_code,
    output logic [ADDR_W-1:0] mux_addr,
    output logic              busy,
    output logic              do_o,
    output logic              do_oe
);
    localparam int CNT_W = $clog2(DATA_W > ADDR_W ? DATA_W : ADDR_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W - 1);

    seq_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             shift_en, latch_en, conv_en;
    logic [DATA_W-1:0] sar;

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        shift_en = 1'b0;
        latch_en = 1'b0;
        conv_en  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (di) begin
                    state_nx = ST_ADDR;
                    cnt_nx   = '0;
                end
            end
            ST_ADDR: begin
                shift_en = 1'b1;
                if (cnt == LAST_ADDR) begin
                    latch_en = 1'b1;
                    state_nx = ST_CONV;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            ST_CONV: begin
                conv_en = 1'b1;
                if (cnt == LAST_BIT) begin
                    state_nx = ST_TAIL;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CNT_W'(1);
                end
            end
            ST_TAIL: begin
                state_nx = LSB_REPLAY ? ST_REPLAY : ST_DONE;
                cnt_nx   = '0;
            end
            ST_REPLAY: begin
                if (cnt == LAST_BIT) state_nx = ST_DONE;
                else                 cnt_nx   = cnt + CNT_W'(1);
            end
            ST_DONE: begin
                state_nx = ST_DONE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    sar_addr_shift #(.AW(ADDR_W)) u_addr (
        .clk      (sclk),
        .clr      (cs_n),
        .shift_en (shift_en),
        .latch_en (latch_en),
        .di       (di),
        .addr_o   (mux_addr)
    );

    sar_core #(.W(DATA_W), .CNT_W(CNT_W)) u_core (
        .clk      (sclk),
        .clr      (cs_n),
        .active   (conv_en),
        .step_idx (cnt),
        .comp_hi  (comp_hi),
        .trial    (trial_code),
        .sar      (sar)
    );

    sar_out_stage #(.W(DATA_W), .CNT_W(CNT_W)) u_out (
        .clk   (sclk),
        .clr   (cs_n),
        .state (state),
        .cnt   (cnt),
        .sar   (sar),
        .do_o  (do_o),
        .do_oe (do_oe),
        .busy  (busy)
    );

    AST_QUIET_WHILE_LISTEN: assert property (@(posedge sclk) disable iff (cs_n)
        (state == ST_IDLE || state == ST_ADDR) |-> !do_oe); // R11
    AST_LEAD_ZERO: assert property (@(posedge sclk) disable iff (cs_n)
        (state == ST_CONV && cnt == '0) |-> (do_oe && !do_o)); // R5
    AST_BUSY_ONLY_CONV: assert property (@(posedge sclk) disable iff (cs_n)
        busy |-> (state == ST_CONV)); // R4
    AST_BUSY_HELD: assert property (@(posedge sclk) disable iff (cs_n)
        (state == ST_CONV && cnt != '0) |-> busy); // R4
    AST_DONE_HIZ: assert property (@(posedge sclk) disable iff (cs_n)
        (state == ST_DONE) |-> !do_oe); // R9
    AST_CHAN_HOLD: assert property (@(posedge sclk) disable iff (cs_n)
        (state == ST_CONV) |=> $stable(mux_addr)); // R3
endmodule

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       di   = 1'b0;
    logic [7:0] vin  = 8'h00;
    logic       comp_a, comp_b;
    logic [7:0] trial_a, trial_b;
    logic [2:0] addr_a, addr_b;
    logic       busy_a, busy_b, do_a, do_b, oe_a, oe_b;

    int checks = 0;
    int errors = 0;
    int q_a[$];
    int q_b[$];
    int busy_cnt_a = 0;
    int busy_cnt_b = 0;
    bit mon_en = 1'b1;

    always #5 sclk = ~sclk;

    assign comp_a = (vin >= trial_a);
    assign comp_b = (vin >= trial_b);

    sar_serial_seq #(.DATA_W(8), .ADDR_W(3), .LSB_REPLAY(1'b1)) u_dut (
        .sclk(sclk), .cs_n(cs_n), .di(di), .comp_hi(comp_a),
        .trial_code(trial_a), .mux_addr(addr_a), .busy(busy_a),
        .do_o(do_a), .do_oe(oe_a)
    );

    sar_serial_seq #(.DATA_W(8), .ADDR_W(3), .LSB_REPLAY(1'b0)) u_dut_msb (
        .sclk(sclk), .cs_n(cs_n), .di(di), .comp_hi(comp_b),
        .trial_code(trial_b), .mux_addr(addr_b), .busy(busy_b),
        .do_o(do_b), .do_oe(oe_b)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitors: pop one expected slot per rising edge while the output is enabled
    always @(posedge sclk) begin
        #1;
        if (!cs_n && mon_en) begin
            if (busy_a) busy_cnt_a++;
            if (oe_a) begin
                if (q_a.size() == 0) chk("R9 replay unit unexpected drive", 1, 0);
                else chk("R7/R8 replay unit slot", int'(do_a), q_a.pop_front());
            end
        end
    end

    always @(posedge sclk) begin
        #1;
        if (!cs_n && mon_en) begin
            if (busy_b) busy_cnt_b++;
            if (oe_b) begin
                if (q_b.size() == 0) chk("R8/R9 msb-only unit unexpected drive", 1, 0);
                else chk("R7 msb-only unit slot", int'(do_b), q_b.pop_front());
            end
        end
    end

    task automatic send_header(input logic [2:0] ch);
        @(negedge sclk); di = 1'b1;
        @(negedge sclk); di = ch[2];
        @(negedge sclk); di = ch[1];
        @(negedge sclk); di = ch[0];
        @(posedge sclk); #1;
    endtask

    task automatic run_conv(input logic [2:0] ch, input logic [7:0] v, input bit noisy);
        @(negedge sclk); cs_n = 1'b1; di = 1'b0; vin = v;
        repeat (2) @(negedge sclk);
        chk("R1 busy in select-high", int'(busy_a), 0);
        chk("R1 oe in select-high", int'(oe_a), 0);
        chk("R1 addr in select-high", int'(addr_a), 0);
        q_a.delete(); q_b.delete();
        q_a.push_back(0); q_b.push_back(0);
        for (int i = 7; i >= 0; i--) begin q_a.push_back(int'(v[i])); q_b.push_back(int'(v[i])); end
        for (int i = 0; i < 8; i++) q_a.push_back(int'(v[i]));
        busy_cnt_a = 0; busy_cnt_b = 0;
        cs_n = 1'b0;
        repeat (3) @(negedge sclk);
        chk("R2 no start on zeros busy", int'(busy_a), 0);
        chk("R2 no start on zeros oe", int'(oe_a), 0);
        send_header(ch);
        chk("R3 channel latched", int'(addr_a), int'(ch));
        chk("R6 first trial", int'(trial_a), 8'h80);
        chk("R11 oe low while listening", int'(oe_a), 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge sclk);
            if (noisy) di = ~di; else di = 1'b0;
        end
        chk("R3 channel held", int'(addr_a), int'(ch));
        chk("R7/R8 replay unit stream consumed", q_a.size(), 0);
        chk("R8 msb-only stream consumed", q_b.size(), 0);
        chk("R4 busy window length", busy_cnt_a, 8);
        chk("R4 busy window length msb-only", busy_cnt_b, 8);
        chk("R9 output parked", int'(oe_a), 0);
        chk("R10 result unaffected by di", int'(trial_a), 0);
    endtask

    initial begin
        repeat (100000) @(posedge sclk);
        chk("watchdog expired", 1, 0);
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge sclk);
        chk("R1 reset busy", int'(busy_a), 0);
        chk("R1 reset oe", int'(oe_a), 0);
        chk("R1 reset trial", int'(trial_a), 0);

        run_conv(3'd0, 8'h00, 1'b0);
        run_conv(3'd7, 8'hFF, 1'b0);
        run_conv(3'd5, 8'hA5, 1'b1);   // R10: di toggles during conversion
        run_conv(3'd2, 8'h80, 1'b0);
        run_conv(3'd3, 8'h7F, 1'b1);   // R10
        run_conv(3'd6, 8'h01, 1'b0);

        // R9: start bits after the last slot without a select cycle do nothing
        q_a.delete(); q_b.delete();
        for (int i = 0; i < 12; i++) begin
            @(negedge sclk); di = (i % 2 == 0);
        end
        @(posedge sclk); #1;
        chk("R9 no restart busy", int'(busy_a), 0);
        chk("R9 no restart oe", int'(oe_a), 0);
        chk("R9 no restart addr kept", int'(addr_a), 6);

        // R1: abort mid-conversion
        mon_en = 1'b0;
        @(negedge sclk); cs_n = 1'b1; di = 1'b0; vin = 8'hC3;
        repeat (2) @(negedge sclk);
        cs_n = 1'b0;
        send_header(3'd4);
        repeat (3) @(negedge sclk);
        chk("R4 busy during conversion", int'(busy_a), 1);
        #2; cs_n = 1'b1; #1;
        chk("R1 abort busy", int'(busy_a), 0);
        chk("R1 abort oe", int'(oe_a), 0);
        chk("R1 abort addr", int'(addr_a), 0);
        chk("R1 abort trial", int'(trial_a), 0);
        mon_en = 1'b1;

        run_conv(3'd1, 8'h5A, 1'b1);
        finish_sim();
    end
endmodule